// File: doc/BRIEF.md
# PWM Duty and Period Conditioner

This block sits ahead of a PWM waveform generator and turns raw period and duty requests into values that are safe to switch. The period request is raised to a programmable floor. The duty request is a signed two's-complement number, and only its magnitude is used; that magnitude is capped at the conditioned period. The block can limit how far the duty moves at each PWM cycle. It then forces on-times or off-times that are too narrow to fully off or fully on.

The generator pulses `cycle_start_i` for one clock at the start of every PWM cycle. The block samples all of its inputs in that clock. The conditioned values appear on the outputs one clock later and stay fixed until the next pulse. The slew state is the rate-limited duty before coercion. It is held inside the block, so a ramp keeps moving through a region that coercion forces to zero. A build parameter can remove the slew stage completely. At run time, an enable input bypasses the slew stage.

Top module: `pwm_duty_conditioner`

## Requirements
- R1: While `rst` is high at a rising clock edge, `duty_o` becomes 0 and `period_o` takes the value of `min_period_i`. The internal slew state is also cleared to 0.
- R2: The outputs change only at the rising edge where `cycle_start_i` is 1. At every other edge they hold their values.
- R3: At an update, `period_o` becomes the larger of `period_req_i` and `min_period_i`. Both are unsigned.
- R4: `duty_req_i` is read as signed two's complement, and its absolute value is the duty target. For the most negative code, the target is 2^(W-1).
- R5: A duty target larger than the conditioned period is reduced to the conditioned period.
- R6: With `rate_en_i` = 1, the slew state moves toward the target by at most `rate_step_i` per update. It lands exactly on the target when the target is no more than `rate_step_i` away. A step of 0 freezes it.
- R7: With `rate_en_i` = 0, the slew state takes the clamped target directly.
- R8: Coercion acts on the slew state but never writes back into it. A ramp that starts from 0 through the narrow-pulse zone keeps advancing even while `duty_o` is 0.
- R9: If the slew state is strictly less than `duty_limit_i`, `duty_o` becomes 0.
- R10: If the slew state plus `duty_limit_i` is strictly greater than the conditioned period, `duty_o` becomes the full period. Equality on either side, here or in R9, leaves the value unchanged.
- R11: When the conditions of R9 and R10 both hold, R9 wins and `duty_o` is 0.
- R12: `duty_o` never exceeds `period_o`. If the period drops below the slew state, the slew state is first cut to the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start_i | input | 1 | One-clock pulse marking the start of a PWM cycle |
| period_req_i | input | 16 | Requested period in ticks, unsigned |
| duty_req_i | input | 16 | Requested duty in ticks, signed two's complement |
| min_period_i | input | 16 | Period floor in ticks |
| duty_limit_i | input | 16 | Narrowest allowed on-time and off-time in ticks |
| rate_step_i | input | 16 | Largest duty change per cycle in ticks |
| rate_en_i | input | 1 | 1 enables the slew limit |
| period_o | output | 16 | Conditioned period |
| duty_o | output | 16 | Conditioned duty |

## Verification
A corrupted slew register shows up as a wrong `duty_o` one clock after the next cycle-start pulse. In a ramp, it then shows in every following cycle, because each step builds on the stored value. If that value sits inside the narrow-pulse zone, coercion hides it until a later step carries it out of the zone. The bench therefore steps a ramp through that zone and checks both later values. An update latched at the wrong edge shows up as an output that changes between pulses, which the hold checks catch in the cycle it happens.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int TICK_W = 16;
    localparam int WIDE_W = TICK_W + 1;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [WIDE_W-1:0] wide_t;

    // Period and duty travelling together through the datapath.
    typedef struct packed {
        tick_t period;
        tick_t duty;
    } cond_t;

    // Absolute value of a signed request; the most negative code maps to 2^(W-1).
    function automatic tick_t mag_of(input logic signed [TICK_W-1:0] v);
        tick_t r;
        if (v[TICK_W-1]) r = tick_t'(-v);
        else             r = tick_t'(v);
        return r;
    endfunction

    function automatic tick_t max_of(input tick_t a, input tick_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic tick_t min_of(input tick_t a, input tick_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic wide_t widen(input tick_t a);
        return {1'b0, a};
    endfunction

endpackage

// File: rtl/pdc_period_stage.sv
module pdc_period_stage
    import pdc_pkg::*;
(
    input  tick_t period_req,
    input  tick_t min_period,
    input  tick_t duty_req,
    output cond_t target
);
    tick_t per_c;
    tick_t mag;

    always_comb begin
        per_c         = max_of(period_req, min_period);
        mag           = mag_of(duty_req);
        target.period = per_c;
        target.duty   = min_of(mag, per_c);
    end
endmodule

// File: rtl/pdc_slew_stage.sv
module pdc_slew_stage
    import pdc_pkg::*;
#(
    parameter bit SLEW_EN = 1'b1
) (
    input  tick_t prev,
    input  cond_t target,
    input  tick_t step,
    input  logic  en,
    output tick_t next
);
    tick_t stepped;

    generate
        if (SLEW_EN) begin : g_slew
            tick_t diff;
            always_comb begin
                if (!en) begin
                    diff    = '0;
                    stepped = target.duty;
                end else if (target.duty >= prev) begin
                    diff    = target.duty - prev;
                    stepped = (diff > step) ? prev + step : target.duty;
                end else begin
                    diff    = prev - target.duty;
                    stepped = (diff > step) ? prev - step : target.duty;
                end
            end
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = en ^ (^step) ^ (^prev);
            assign stepped   = target.duty;
        end
    endgenerate

    // A shrinking period cuts a state that now lies beyond it.
    assign next = min_of(stepped, target.period);
endmodule

// File: rtl/pdc_coerce_stage.sv
module pdc_coerce_stage
    import pdc_pkg::*;
(
    input  tick_t slewed,
    input  tick_t period,
    input  tick_t limit,
    output tick_t duty
);
    wide_t upper;

    always_comb begin
        upper = widen(slewed) + widen(limit);
        if (slewed < limit)
            duty = '0;              // zero wins when both apply
        else if (upper > widen(period))
            duty = period;
        else
            duty = slewed;
    end
endmodule

// File: rtl/pwm_duty_conditioner.sv
module pwm_duty_conditioner
    import pdc_pkg::*;
#(
    parameter bit SLEW_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cycle_start_i,
    input  logic [pdc_pkg::TICK_W-1:0] period_req_i,
    input  logic [pdc_pkg::TICK_W-1:0] duty_req_i,
    input  logic [pdc_pkg::TICK_W-1:0] min_period_i,
    input  logic [pdc_pkg::TICK_W-1:0] duty_limit_i,
    input  logic [pdc_pkg::TICK_W-1:0] rate_step_i,
    input  logic                      rate_en_i,
    output logic [pdc_pkg::TICK_W-1:0] period_o,
    output logic [pdc_pkg::TICK_W-1:0] duty_o
);
    cond_t target;
    tick_t slew_q;
    tick_t slew_nx;
    tick_t duty_nx;
    cond_t out_q;

    pdc_period_stage u_period (
        .period_req (period_req_i),
        .min_period (min_period_i),
        .duty_req   (duty_req_i),
        .target     (target)
    );

    pdc_slew_stage #(.SLEW_EN(SLEW_EN)) u_slew (
        .prev   (slew_q),
        .target (target),
        .step   (rate_step_i),
        .en     (rate_en_i),
        .next   (slew_nx)
    );

    pdc_coerce_stage u_coerce (
        .slewed (slew_nx),
        .period (target.period),
        .limit  (duty_limit_i),
        .duty   (duty_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.period <= min_period_i;
            out_q.duty   <= '0;
            slew_q       <= '0;
        end else if (cycle_start_i) begin
            out_q.period <= target.period;
            out_q.duty   <= duty_nx;
            slew_q       <= slew_nx;
        end
    end

    assign period_o = out_q.period;
    assign duty_o   = out_q.duty;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (duty_o == '0) && (slew_q == '0));

    a_r2_hold_between_starts: assert property (@(posedge clk) disable iff (rst)
        !cycle_start_i |=> $stable(period_o) && $stable(duty_o));

    a_r3_period_floor: assert property (@(posedge clk) disable iff (rst)
        cycle_start_i |=> (period_o >= $past(min_period_i)) && (period_o >= $past(period_req_i)));

    a_r12_duty_within_period: assert property (@(posedge clk) disable iff (rst)
        duty_o <= period_o);

    a_r10_no_narrow_pulse: assert property (@(posedge clk) disable iff (rst)
        cycle_start_i |=> (duty_o == '0) || (duty_o == period_o) ||
            ((duty_o >= $past(duty_limit_i)) &&
             (widen(duty_o) + widen($past(duty_limit_i)) <= widen(period_o))));

    generate
        if (SLEW_EN) begin : g_slew_chk
            tick_t prev_slew;
            tick_t step_d;
            logic  chk_armed;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chk_armed <= 1'b0;
                    prev_slew <= '0;
                    step_d    <= '0;
                end else begin
                    chk_armed <= cycle_start_i && rate_en_i && (slew_q <= target.period);
                    prev_slew <= slew_q;
                    step_d    <= rate_step_i;
                end
            end
            a_r6_slew_step: assert property (@(posedge clk) disable iff (rst)
                chk_armed |-> ((slew_q >= prev_slew) ? (slew_q - prev_slew) : (prev_slew - slew_q)) <= step_d);
        end
    endgenerate
endmodule

// File: tb/pwm_duty_conditioner_tb_top.sv
module pwm_duty_conditioner_tb_top;

    typedef struct packed {
        logic [15:0] preq;
        logic [15:0] dreq;
        logic [15:0] minp;
        logic [15:0] lim;
        logic [15:0] step;
        logic        ren;
        logic [15:0] eper;
        logic [15:0] eduty;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{16'd2000, 16'd500,    16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd500 },  // R7 pass-through
        '{16'd2000, 16'hFD44,   16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd700 },  // R4 -700
        '{16'd500,  16'd300,    16'd1000, 16'd100, 16'd0,    1'b0, 16'd1000, 16'd300 },  // R3 floor
        '{16'd2000, 16'd50,     16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd0   },  // R9
        '{16'd2000, 16'd1950,   16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd2000},  // R10
        '{16'd2000, 16'd1900,   16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd1900},  // R10 equality
        '{16'd2000, 16'd100,    16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd100 },  // R9 equality
        '{16'd2000, 16'd5000,   16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd2000},  // R5
        '{16'd2000, 16'h8000,   16'd1000, 16'd100, 16'd0,    1'b0, 16'd2000, 16'd2000},  // R4 most negative, R5
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd300,  1'b1, 16'd2000, 16'd1700},  // R6 down
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd300,  1'b1, 16'd2000, 16'd1400},  // R6
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd300,  1'b1, 16'd2000, 16'd1100},  // R6
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd300,  1'b1, 16'd2000, 16'd1000},  // R6 land
        '{16'd2000, 16'd1200,   16'd1000, 16'd100, 16'd300,  1'b1, 16'd2000, 16'd1200},  // R6 up within step
        '{16'd2000, 16'd0,      16'd1000, 16'd100, 16'd0,    1'b1, 16'd2000, 16'd1200},  // R6 step 0
        '{16'd2000, 16'd0,      16'd1000, 16'd100, 16'd1250, 1'b1, 16'd2000, 16'd0   },  // R6 to zero
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd60,   1'b1, 16'd2000, 16'd0   },  // R8 state 60
        '{16'd2000, 16'd1000,   16'd1000, 16'd100, 16'd60,   1'b1, 16'd2000, 16'd120 },  // R8 state 120
        '{16'd800,  16'd1000,   16'd1000, 16'd100, 16'd60,   1'b1, 16'd1000, 16'd180 },  // R8, R3
        '{16'd1000, 16'd550,    16'd1000, 16'd600, 16'd0,    1'b0, 16'd1000, 16'd0   },  // R11
        '{16'd1000, 16'd650,    16'd1000, 16'd600, 16'd0,    1'b0, 16'd1000, 16'd1000},  // R10
        '{16'd2500, 16'd2900,   16'd3000, 16'd100, 16'd0,    1'b0, 16'd3000, 16'd2900},  // R3 new floor
        '{16'd1000, 16'd1000,   16'd1000, 16'd100, 16'd10,   1'b1, 16'd1000, 16'd1000}   // R12 cut
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cycle_start_i = 1'b0;
    logic [15:0] period_req_i = '0;
    logic [15:0] duty_req_i = '0;
    logic [15:0] min_period_i = 16'd1000;
    logic [15:0] duty_limit_i = 16'd100;
    logic [15:0] rate_step_i = '0;
    logic        rate_en_i = 1'b0;
    logic [15:0] period_o;
    logic [15:0] duty_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_duty_conditioner dut_i (
        .clk           (clk),
        .rst           (rst),
        .cycle_start_i (cycle_start_i),
        .period_req_i  (period_req_i),
        .duty_req_i    (duty_req_i),
        .min_period_i  (min_period_i),
        .duty_limit_i  (duty_limit_i),
        .rate_step_i   (rate_step_i),
        .rate_en_i     (rate_en_i),
        .period_o      (period_o),
        .duty_o        (duty_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 period", period_o, 16'd1000);
        check("R1 duty", duty_o, 16'd0);

        // R2: requests move but no start pulse arrives
        period_req_i = 16'd3000;
        duty_req_i   = 16'd1500;
        repeat (5) @(negedge clk);
        check("R2 period hold", period_o, 16'd1000);
        check("R2 duty hold", duty_o, 16'd0);

        for (int i = 0; i < NV; i++) begin
            period_req_i  = VECS[i].preq;
            duty_req_i    = VECS[i].dreq;
            min_period_i  = VECS[i].minp;
            duty_limit_i  = VECS[i].lim;
            rate_step_i   = VECS[i].step;
            rate_en_i     = VECS[i].ren;
            cycle_start_i = 1'b1;
            @(negedge clk);
            cycle_start_i = 1'b0;
            check($sformatf("vec %0d period (R3)", i), period_o, VECS[i].eper);
            check($sformatf("vec %0d duty (R4-R12 per row)", i), duty_o, VECS[i].eduty);
        end

        // R2: hold after an update while inputs change
        duty_req_i   = 16'd10;
        period_req_i = 16'd5000;
        repeat (3) @(negedge clk);
        check("R2 hold after update period", period_o, 16'd1000);
        check("R2 hold after update duty", duty_o, 16'd1000);

        // R1: reset mid-run reloads floor, clears duty and slew state
        min_period_i = 16'd1200;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset period", period_o, 16'd1200);
        check("R1 reset duty", duty_o, 16'd0);
        // slew state cleared: ramp from 0 by 200 gives 200
        period_req_i = 16'd2000;
        duty_req_i   = 16'd1000;
        duty_limit_i = 16'd100;
        rate_step_i  = 16'd200;
        rate_en_i    = 1'b1;
        cycle_start_i = 1'b1;
        @(negedge clk);
        cycle_start_i = 1'b0;
        check("R1 R6 slew from cleared state", duty_o, 16'd200);

        finish_run();
    end

endmodule